// File: doc/BRIEF.md
# Pulse Width and Edge-Count Meter

This block observes a single digital input and turns its timing into numbers. One counter is shared by two modes that exclude each other. In width mode it reports how many clock cycles separate a chosen start edge from a chosen end edge. In frequency mode it opens a window of a programmed number of cycles and reports how many chosen edges fell inside it. Each finished measurement leaves the block as a one-cycle valid strobe together with the count, which feeds a downstream accumulator.

A measurement can be launched in two ways. In free-running operation it begins at the first qualifying input edge once the block is enabled. With trigger gating on, a single-cycle trigger pulse starts it instead. The block then re-arms by itself after every result. A trigger that lands while a measurement is under way discards that measurement and starts again, and it tells the accumulator to restart too. The counter saturates at its maximum rather than wrapping, and it raises an overflow flag that stays set until software clears it explicitly.

Top module: `sig_meter`

## Requirements
- R1: While reset is asserted, measValid, aggrRestart and errOverflow are all 0.
- R2: Each edge selector is two bits: 2'b01 picks rising edges, 2'b10 falling, 2'b11 both, and 2'b00 none. With the start selector at 2'b00 no measurement ever starts in free-running operation.
- R3: In width mode (modeFreq=0), measValue equals the number of clock cycles between the input change matching startSel and the later change matching endSel. measValid is high for one cycle, 3 cycles after the end change is applied.
- R4: In frequency mode (modeFreq=1, winLen of 2 or more), each window lasts winLen cycles and starts the cycle after the start event. measValue counts the startSel edges detected in the window. Windows follow back to back, so a result is produced every winLen cycles.
- R5: With trigEn=0 and enable=1, a measurement begins at the first startSel edge. In frequency mode that opening edge is not itself counted.
- R6: With trigEn=1, input edges do not start the first measurement. A trigger pulse applied in cycle t starts counting, and a width measurement ending at an end change applied in cycle f reports f-t+2.
- R7: A trigger during a running measurement drops that measurement with no valid strobe and starts a new one. Every accepted trigger raises aggrRestart for one cycle, one cycle after the pulse.
- R8: After a width result the block waits for the next startSel edge without needing a new trigger. If the end edge also matches startSel, the next measurement starts in that same cycle, which gives period measurement.
- R9: The count saturates at its all-ones value. A cycle that would carry past it sets errOverflow.
- R10: errOverflow stays set across later measurements and trigger restarts. Only a cycle with errClr=1 clears it.
- R11: With enable=0 the block is idle and produces no valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; when low the block is held idle |
| modeFreq | input | 1 | 0 selects width mode, 1 selects frequency mode |
| startSel | input | 2 | Start-edge selector; also the counted edge in frequency mode |
| endSel | input | 2 | End-edge selector for width mode |
| winLen | input | WIN_W | Window length in cycles for frequency mode |
| trigEn | input | 1 | Starts measurements on trigger instead of on input edge |
| trigPulse | input | 1 | Single-cycle trigger pulse |
| errClr | input | 1 | Clears the sticky overflow flag |
| sigIn | input | 1 | Asynchronous signal under measurement |
| measValid | output | 1 | One-cycle strobe when a measurement completes |
| measValue | output | CNT_W | Result of the last measurement |
| aggrRestart | output | 1 | One-cycle pulse telling the accumulator to restart |
| errOverflow | output | 1 | Sticky counter-saturation flag |

## Verification
An input change reaches the control logic on the third rising clock edge after it is applied, because it passes two synchronizer flops and an edge-detect flop. The width result is therefore visible in the sampling window 3 cycles after the end change. A frequency window whose start change was applied in cycle s reports in cycle s+k*winLen+3, and aggrRestart appears one cycle after the trigger. The bench drives every input at the falling clock edge and counts cycles at that edge. It time-stamps each valid strobe, then compares both the value and the cycle against arithmetic predictions computed from these latencies.

// File: rtl/sig_meter_pkg.sv
package sig_meter_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [1:0] EDGE_NONE = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_REARM = 2'd2,
    ST_RUN   = 2'd3
  } meterState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;   // begin a new measurement
    logic run;    // advance the counter this cycle
    logic done;   // publish the result
    logic trig;   // measurement (re)started by trigger
  } meterStrb_t;

  function automatic logic edgeMatch(input logic [1:0] sel, input logic rise, input logic fall);
    return (sel[0] & rise) | (sel[1] & fall);
  endfunction
endpackage

// File: rtl/sig_meter_edge.sv
module sig_meter_edge
  import sig_meter_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sigIn,
  input  logic [1:0] startSel,
  input  logic [1:0] endSel,
  output logic       startHit,
  output logic       endHit
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chainQ;
  logic riseNow;
  logic fallNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chainQ <= '0;
    else       chainQ <= {chainQ[CHAIN-2:0], sigIn};
  end

  assign riseNow  =  chainQ[SYNC_STAGES-1] & ~chainQ[SYNC_STAGES];
  assign fallNow  = ~chainQ[SYNC_STAGES-1] &  chainQ[SYNC_STAGES];
  assign startHit = edgeMatch(startSel, riseNow, fallNow);
  assign endHit   = edgeMatch(endSel, riseNow, fallNow);
endmodule

// File: rtl/sig_meter_ctl.sv
module sig_meter_ctl
  import sig_meter_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       modeFreq,
  input  logic       trigEn,
  input  logic       trigPulse,
  input  logic       startHit,
  input  logic       endHit,
  input  logic       winLast,
  output meterStrb_t strb
);
  timeunit 1ns;
  timeprecision 100ps;

  meterState_t stQ, stD;
  logic trigHit;

  assign trigHit = trigEn & trigPulse;

  always_comb begin
    stD  = stQ;
    strb = '0;
    if (!enable) begin
      stD = ST_IDLE;
    end else if (trigHit) begin
      strb.load = 1'b1;
      strb.trig = 1'b1;
      stD       = ST_RUN;
    end else begin
      case (stQ)
        ST_IDLE, ST_ARMED: begin
          if (!trigEn && startHit) begin
            strb.load = 1'b1;
            stD       = ST_RUN;
          end else begin
            stD = ST_ARMED;
          end
        end
        ST_REARM: begin
          if (startHit) begin
            strb.load = 1'b1;
            stD       = ST_RUN;
          end
        end
        ST_RUN: begin
          if (modeFreq) begin
            if (winLast) begin
              strb.done = 1'b1;
              strb.load = 1'b1;
            end else begin
              strb.run = 1'b1;
            end
          end else if (endHit) begin
            strb.done = 1'b1;
            if (startHit) strb.load = 1'b1;
            else          stD = ST_REARM;
          end else begin
            strb.run = 1'b1;
          end
        end
        default: stD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stD;
  end

  p_done_in_run_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |-> (stQ == ST_RUN));

  p_trig_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    (enable && trigEn && trigPulse) |=> (stQ == ST_RUN));

  p_rearm_r8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !modeFreq && strb.done && !strb.load) |=> (stQ == ST_REARM));
endmodule

// File: rtl/sig_meter_dp.sv
module sig_meter_dp
  import sig_meter_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  meterStrb_t       strb,
  input  logic             modeFreq,
  input  logic             cntHit,
  input  logic [WIN_W-1:0] winLen,
  input  logic             errClr,
  output logic             winLast,
  output logic             measValid,
  output logic [CNT_W-1:0] measValue,
  output logic             aggrRestart,
  output logic             errOverflow
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cntQ;
  logic [WIN_W-1:0] tmrQ;
  logic             incBit;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] satVal;
  logic             accum;

  assign incBit  = modeFreq ? cntHit : 1'b1;
  assign sum     = {1'b0, cntQ} + {{CNT_W{1'b0}}, incBit};
  assign satVal  = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
  assign accum   = strb.run | (strb.done & modeFreq);
  assign winLast = (tmrQ == winLen - WIN_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      tmrQ <= '0;
    end else if (strb.load) begin
      cntQ <= modeFreq ? '0 : CNT_W'(1);
      tmrQ <= '0;
    end else if (strb.run) begin
      cntQ <= satVal;
      tmrQ <= tmrQ + WIN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      measValid   <= 1'b0;
      measValue   <= '0;
      aggrRestart <= 1'b0;
      errOverflow <= 1'b0;
    end else begin
      measValid   <= strb.done;
      aggrRestart <= strb.trig;
      errOverflow <= (errOverflow & ~errClr) | (accum & sum[CNT_W]);
      if (strb.done) measValue <= modeFreq ? satVal : cntQ;
    end
  end

  p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && cntQ == CNT_MAX) |=> (cntQ == CNT_MAX && errOverflow));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (errOverflow && !errClr) |=> errOverflow);

  p_win_reset_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (tmrQ == '0));
endmodule

// File: rtl/sig_meter.sv
module sig_meter
  import sig_meter_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             modeFreq,
  input  logic [1:0]       startSel,
  input  logic [1:0]       endSel,
  input  logic [WIN_W-1:0] winLen,
  input  logic             trigEn,
  input  logic             trigPulse,
  input  logic             errClr,
  input  logic             sigIn,
  output logic             measValid,
  output logic [CNT_W-1:0] measValue,
  output logic             aggrRestart,
  output logic             errOverflow
);
  timeunit 1ns;
  timeprecision 100ps;

  logic       startHit;
  logic       endHit;
  logic       winLast;
  meterStrb_t strb;

  sig_meter_edge #(.SYNC_STAGES(2)) u_edge (
    .clk      (clk),
    .rstN     (rstN),
    .sigIn    (sigIn),
    .startSel (startSel),
    .endSel   (endSel),
    .startHit (startHit),
    .endHit   (endHit)
  );

  sig_meter_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .modeFreq  (modeFreq),
    .trigEn    (trigEn),
    .trigPulse (trigPulse),
    .startHit  (startHit),
    .endHit    (endHit),
    .winLast   (winLast),
    .strb      (strb)
  );

  sig_meter_dp #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .modeFreq    (modeFreq),
    .cntHit      (startHit),
    .winLen      (winLen),
    .errClr      (errClr),
    .winLast     (winLast),
    .measValid   (measValid),
    .measValue   (measValue),
    .aggrRestart (aggrRestart),
    .errOverflow (errOverflow)
  );

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !measValid);
endmodule

// File: tb/sig_meter_bench.sv
module sig_meter_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CW = 5;
  localparam int WW = 5;
  localparam int WIN = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, modeFreq = 1'b0, trigEn = 1'b0, trigPulse = 1'b0, errClr = 1'b0, sigIn = 1'b0;
  logic [1:0] startSel = 2'b01, endSel = 2'b10;
  logic [WW-1:0] winLen = WW'(WIN);
  logic measValid, aggrRestart, errOverflow;
  logic [CW-1:0] measValue;

  int checks = 0, errors = 0, cyc = 0, nv = 0, wd = 0;
  int vals[32];
  int stamp[32];

  always #2.5 clk = ~clk;

  sig_meter #(.CNT_W(CW), .WIN_W(WW)) u_sig_meter (
    .clk(clk), .rstN(rstN), .enable(enable), .modeFreq(modeFreq),
    .startSel(startSel), .endSel(endSel), .winLen(winLen), .trigEn(trigEn),
    .trigPulse(trigPulse), .errClr(errClr), .sigIn(sigIn),
    .measValid(measValid), .measValue(measValue), .aggrRestart(aggrRestart),
    .errOverflow(errOverflow)
  );

  always @(posedge clk) begin
    wd++;
    if (wd > 50000) begin
      checks++; errors++;
      $display("FAIL watchdog expired (all requirements) actual=%0d expected<=50000", wd);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (measValid && nv < 32) begin
      vals[nv] = int'(measValue);
      stamp[nv] = cyc;
      nv++;
    end
  endtask

  // high pulse of h cycles; width expected from the rise/fall distance
  task automatic widthPulse(input int h, input int exp, input string tag);
    int c0;
    nv = 0; c0 = cyc;
    sigIn = 1'b1;
    repeat (h) step();
    sigIn = 1'b0;
    repeat (8) step();
    chk(nv, 1, {tag, " count"});
    chk(vals[0], exp, {tag, " value"});
    chk(stamp[0], c0 + h + 3, {tag, " latency"});
  endtask

  task automatic restartBlock();
    enable = 1'b0;
    repeat (3) step();
    enable = 1'b1;
  endtask

  task automatic runFreq(input logic [1:0] sel, input int p);
    int s, st, q;
    enable = 1'b0; sigIn = 1'b0;
    repeat (5) step();
    startSel = sel; nv = 0; s = cyc; enable = 1'b1;
    for (int i = 0; i < 3 * WIN + p + 8; i++) begin
      sigIn = ((i / p) % 2 == 0);
      step();
    end
    enable = 1'b0; sigIn = 1'b0;
    if (sel == 2'b00) begin
      chk(nv, 0, "R2 no-edge selector gives no result");
    end else begin
      q  = (sel == 2'b11) ? p : 2 * p;
      st = (sel == 2'b10) ? s + p : s;
      chk(nv >= 3, 1, "R4 three windows reported");
      for (int k = 1; k <= 3; k++) begin
        chk(vals[k-1], (k * WIN) / q - ((k - 1) * WIN) / q, $sformatf("R4 R2 R5 sel=%0d p=%0d win%0d count", sel, p, k));
        chk(stamp[k-1], st + k * WIN + 3, $sformatf("R4 sel=%0d p=%0d win%0d timing", sel, p, k));
      end
    end
  endtask

  initial begin
    int t, f, c0;
    repeat (3) @(negedge clk);
    chk(measValid, 0, "R1 reset valid");
    chk(aggrRestart, 0, "R1 reset restart");
    chk(errOverflow, 0, "R1 reset overflow");
    rstN = 1'b1;
    repeat (2) step();

    // width mode, rising start / falling end
    startSel = 2'b01; endSel = 2'b10; enable = 1'b1;
    repeat (3) step();
    for (int h = 1; h <= 12; h++) begin
      widthPulse(h, h, $sformatf("R3 R5 R8 high width %0d", h));
      repeat (3) step();
    end

    // low pulses: falling start / rising end
    startSel = 2'b10; endSel = 2'b01; sigIn = 1'b1;
    repeat (6) step();
    for (int h = 1; h <= 6; h++) begin
      nv = 0; c0 = cyc;
      sigIn = 1'b0;
      repeat (h) step();
      sigIn = 1'b1;
      repeat (8) step();
      chk(vals[0], h, $sformatf("R2 R3 low width %0d", h));
      chk(nv, 1, "R2 R3 low width count");
    end
    startSel = 2'b01; endSel = 2'b10; sigIn = 1'b0;
    repeat (6) step();

    // period: rise to rise
    startSel = 2'b01; endSel = 2'b01;
    for (int per = 2; per <= 5; per++) begin
      restartBlock();
      nv = 0; c0 = cyc;
      for (int i = 0; i < 4 * per + 8; i++) begin
        sigIn = (i % per == 0) && (i < 4 * per);
        step();
      end
      chk(nv, 3, $sformatf("R8 period %0d count", per));
      for (int k = 1; k <= 3; k++) begin
        chk(vals[k-1], per, $sformatf("R8 period %0d value %0d", per, k));
        chk(stamp[k-1], c0 + k * per + 3, $sformatf("R8 period %0d timing %0d", per, k));
      end
    end
    endSel = 2'b10;
    restartBlock();
    repeat (3) step();

    // saturation and sticky flag
    widthPulse(31, 31, "R9 width at max");
    chk(errOverflow, 0, "R9 no flag at max");
    widthPulse(32, 31, "R9 saturated width");
    chk(errOverflow, 1, "R9 flag set");
    widthPulse(5, 5, "R10 later measurement");
    chk(errOverflow, 1, "R10 flag held after measurement");

    // trigger gating
    trigEn = 1'b1;
    restartBlock();
    repeat (3) step();
    nv = 0;
    sigIn = 1'b1; repeat (4) step(); sigIn = 1'b0; repeat (8) step();
    chk(nv, 0, "R6 edges ignored before trigger");

    nv = 0; t = cyc;
    trigPulse = 1'b1; step(); trigPulse = 1'b0;
    chk(aggrRestart, 1, "R7 restart pulse on trigger");
    step();
    chk(aggrRestart, 0, "R7 restart pulse one cycle");
    sigIn = 1'b1; repeat (4) step();
    f = cyc; sigIn = 1'b0; repeat (8) step();
    chk(nv, 1, "R6 triggered count");
    chk(vals[0], f - t + 2, "R6 triggered width");

    widthPulse(6, 6, "R8 re-arm without new trigger");

    nv = 0;
    trigPulse = 1'b1; step(); trigPulse = 1'b0;
    repeat (2) step();
    sigIn = 1'b1; repeat (2) step();
    t = cyc; trigPulse = 1'b1; step(); trigPulse = 1'b0;
    chk(aggrRestart, 1, "R7 restart pulse mid-measurement");
    repeat (3) step();
    f = cyc; sigIn = 1'b0; repeat (8) step();
    chk(nv, 1, "R7 aborted measurement not reported");
    chk(vals[0], f - t + 2, "R7 restarted width");
    chk(errOverflow, 1, "R10 flag held across trigger restart");

    errClr = 1'b1; step(); errClr = 1'b0;
    chk(errOverflow, 0, "R10 flag cleared by errClr");
    trigEn = 1'b0;

    // frequency sweep
    modeFreq = 1'b1;
    for (int s = 0; s < 4; s++)
      for (int p = 1; p <= 4; p++)
        runFreq(2'(s), p);
    chk(errOverflow, 0, "R9 no overflow in frequency sweep");

    // disabled block
    modeFreq = 1'b0; startSel = 2'b01; enable = 1'b0; nv = 0;
    repeat (3) step();
    for (int i = 0; i < 4; i++) begin
      sigIn = 1'b1; repeat (3) step(); sigIn = 1'b0; repeat (3) step();
    end
    repeat (4) step();
    chk(nv, 0, "R11 no result while disabled");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule